// File: doc/BRIEF.md
# Eight-Bit ALU with Selective Flag Update

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle it takes two operands, a carry input and an operation code. It returns the result and the merged next value of six status flags: half carry, sign, overflow, negative, zero and carry. The result and the merged flags are combinational. A flag register inside the block loads the merged value on every clock edge where the operation is marked valid. The caller decides whether the second operand comes from a register or from an immediate field, and whether the result is written anywhere.

Each operation owns a fixed subset of the flags. Flags outside that subset keep their stored value. The block reports which flags the current operation writes and whether it produces a result to store. Compare operations produce flags only. The carry-chained subtract and compare can only clear the zero flag, never set it, so that a compare or subtract spread over several bytes gives a correct zero flag at the end.

Top module: `alu8`

## Requirements
- R1: ADD (code 0) gives opA+opB and ADC (code 1) gives opA+opB+carryIn. Both write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (bit 7 of the result), Z (result is zero) and S.
- R2: SUB (code 2) gives opA-opB and SBC (code 3) gives opA-opB-carryIn. Both write all six flags. C is the borrow out of bit 7, H is the borrow out of bit 3 and V is signed overflow.
- R3: For SBC and CPC (code 5), Z becomes 1 only if the result is zero and the stored Z was already 1. Otherwise Z becomes 0.
- R4: CP (code 4) and CPC update the flags exactly like SUB and SBC, and hold resultWrite at 0.
- R5: AND (6), OR (7) and XOR (8) write Z, N and S, and force V to 0. C and H keep their stored values.
- R6: COM (9) gives 0xFF-opA, forces C to 1 and V to 0, writes Z, N and S, and leaves H unchanged.
- R7: NEG (10) gives 0-opA and writes all six flags by the subtraction rules of R2. As a result, C=1 whenever opA is not zero, and V=1 only for opA=0x80.
- R8: INC (11) and DEC (12) give opA+1 and opA-1 and write only Z, N, V and S. V is 1 for INC of 0x7F and for DEC of 0x80.
- R9: LSL (13) fills bit 0 with 0 and LSR (14) fills bit 7 with 0. The bit shifted out goes to C, and V becomes N XOR C.
- R10: ROL (15) moves carryIn into bit 0 and ROR (16) moves carryIn into bit 7. The bit shifted out goes to C, and V becomes N XOR C.
- R11: ASR (17) shifts right and keeps bit 7. Bit 0 goes to C, and V becomes N XOR C.
- R12: SWAP (18) exchanges the two nibbles of opA, writes the result and changes no flag.
- R13: The flag vector bit order is C=0, Z=1, N=2, V=3, S=4, H=5. Reset clears all flags. Flags load only on a clock edge with opValid=1. Flags outside flagMask keep their value. S equals N XOR V whenever N or V is written.
- R14: Op codes 19 to 31 write no flag and hold resultWrite at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Loads the flag register at this edge |
| opSel | input | 5 | Operation code |
| opA | input | 8 | First operand (destination value) |
| opB | input | 8 | Second operand, register or immediate |
| carryIn | input | 1 | Carry used by ADC, SBC, CPC, ROL and ROR |
| result | output | 8 | Combinational result |
| resultWrite | output | 1 | Result should be stored |
| flagMask | output | 6 | Flags written by the current operation |
| flagNext | output | 6 | Merged next flag vector |
| flags | output | 6 | Registered flag vector |

## Verification
On every valid cycle the assertions check four things: unmasked flags stay put, the sign flag follows N XOR V, SWAP leaves all flags alone, and the logic group clears overflow. They also check that compares never request a write, that COM sets carry, and that the chained subtract never raises a cleared zero flag. The exact arithmetic values can only be shown by the bench's directed scenarios: half carry and borrow at bit 3, the overflow corners of INC, DEC and NEG, the fill bits of each shift, and multi-byte zero chaining.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int NFLAGS = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [NFLAGS-1:0] MASK_ALL  = 6'b111111;
  localparam logic [NFLAGS-1:0] MASK_ZNV  = 6'b011110;
  localparam logic [NFLAGS-1:0] MASK_ZCNV = 6'b011111;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWAP = 5'd18
  } aluOp_e;

  typedef enum logic [2:0] {
    K_NONE, K_ADDSUB, K_LOGIC, K_STEP, K_SHIFT, K_SWAP
  } unitKind_e;

  // sel codes: logic 0 and,1 or,2 xor,3 com; shift 0 lsl,1 lsr,2 rol,3 ror,4 asr
  typedef struct packed {
    unitKind_e         kind;
    logic              sub;
    logic              useCarry;
    logic              negate;
    logic [2:0]        sel;
    logic              zSticky;
    logic              writeRes;
    logic [NFLAGS-1:0] mask;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [4:0] opSel,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    strobe.kind = K_NONE;
    case (opSel)
      OP_ADD, OP_ADC: begin
        strobe.kind = K_ADDSUB;
        strobe.useCarry = (opSel == OP_ADC);
        strobe.writeRes = 1'b1;
        strobe.mask = MASK_ALL;
      end
      OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
        strobe.kind = K_ADDSUB;
        strobe.sub = 1'b1;
        strobe.useCarry = (opSel == OP_SBC) || (opSel == OP_CPC);
        strobe.zSticky = (opSel == OP_SBC) || (opSel == OP_CPC);
        strobe.writeRes = (opSel == OP_SUB) || (opSel == OP_SBC);
        strobe.mask = MASK_ALL;
      end
      OP_NEG: begin
        strobe.kind = K_ADDSUB;
        strobe.sub = 1'b1;
        strobe.negate = 1'b1;
        strobe.writeRes = 1'b1;
        strobe.mask = MASK_ALL;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobe.kind = K_LOGIC;
        strobe.sel = (opSel == OP_AND) ? 3'd0 : (opSel == OP_OR) ? 3'd1 : 3'd2;
        strobe.writeRes = 1'b1;
        strobe.mask = MASK_ZNV;
      end
      OP_COM: begin
        strobe.kind = K_LOGIC;
        strobe.sel = 3'd3;
        strobe.writeRes = 1'b1;
        strobe.mask = MASK_ZCNV;
      end
      OP_INC, OP_DEC: begin
        strobe.kind = K_STEP;
        strobe.sub = (opSel == OP_DEC);
        strobe.writeRes = 1'b1;
        strobe.mask = MASK_ZNV;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        strobe.kind = K_SHIFT;
        strobe.sel = 3'(opSel - OP_LSL);
        strobe.writeRes = 1'b1;
        strobe.mask = MASK_ZCNV;
      end
      OP_SWAP: begin
        strobe.kind = K_SWAP;
        strobe.writeRes = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  aluStrobe_t        strobe,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  input  logic              zPrev,
  output logic [WIDTH-1:0]  result,
  output logic [NFLAGS-1:0] rawFlags
);

  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] lhs, rhs;
  logic             cBit;
  logic [WIDTH:0]   wide;
  logic [HALF:0]    nib;
  logic [WIDTH-1:0] res;
  logic             cOut, hOut, vOut, nOut, zOut;

  always_comb begin
    lhs  = strobe.negate ? '0 : opA;
    rhs  = strobe.negate ? opA : opB;
    cBit = strobe.useCarry & carryIn;
    if (strobe.sub) begin
      wide = {1'b0, lhs} - {1'b0, rhs} - {{WIDTH{1'b0}}, cBit};
      nib  = {1'b0, lhs[HALF-1:0]} - {1'b0, rhs[HALF-1:0]} - {{HALF{1'b0}}, cBit};
    end else begin
      wide = {1'b0, lhs} + {1'b0, rhs} + {{WIDTH{1'b0}}, cBit};
      nib  = {1'b0, lhs[HALF-1:0]} + {1'b0, rhs[HALF-1:0]} + {{HALF{1'b0}}, cBit};
    end
  end

  always_comb begin
    res  = '0;
    cOut = 1'b0;
    hOut = 1'b0;
    vOut = 1'b0;
    case (strobe.kind)
      K_ADDSUB: begin
        res  = wide[WIDTH-1:0];
        cOut = wide[WIDTH];
        hOut = nib[HALF];
        if (strobe.sub)
          vOut = (lhs[MSB] & ~rhs[MSB] & ~res[MSB]) | (~lhs[MSB] & rhs[MSB] & res[MSB]);
        else
          vOut = (lhs[MSB] & rhs[MSB] & ~res[MSB]) | (~lhs[MSB] & ~rhs[MSB] & res[MSB]);
      end
      K_LOGIC: begin
        case (strobe.sel)
          3'd0:    res = opA & opB;
          3'd1:    res = opA | opB;
          3'd2:    res = opA ^ opB;
          default: res = ~opA;
        endcase
        cOut = 1'b1;
      end
      K_STEP: begin
        res  = strobe.sub ? opA - 1'b1 : opA + 1'b1;
        vOut = strobe.sub ? (opA[MSB] & ~res[MSB]) : (~opA[MSB] & res[MSB]);
      end
      K_SHIFT: begin
        case (strobe.sel)
          3'd0:    begin res = {opA[MSB-1:0], 1'b0};    cOut = opA[MSB]; end
          3'd1:    begin res = {1'b0, opA[MSB:1]};      cOut = opA[0];   end
          3'd2:    begin res = {opA[MSB-1:0], carryIn}; cOut = opA[MSB]; end
          3'd3:    begin res = {carryIn, opA[MSB:1]};   cOut = opA[0];   end
          default: begin res = {opA[MSB], opA[MSB:1]};  cOut = opA[0];   end
        endcase
        vOut = res[MSB] ^ cOut;
      end
      K_SWAP: res = {opA[HALF-1:0], opA[MSB:HALF]};
      default: ;
    endcase
    nOut = res[MSB];
    zOut = (res == '0) & (~strobe.zSticky | zPrev);
  end

  always_comb begin
    result       = res;
    rawFlags     = '0;
    rawFlags[FC] = cOut;
    rawFlags[FZ] = zOut;
    rawFlags[FN] = nOut;
    rawFlags[FV] = vOut;
    rawFlags[FS] = nOut ^ vOut;
    rawFlags[FH] = hOut;
  end

endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [4:0]        opSel,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  output logic [WIDTH-1:0]  result,
  output logic              resultWrite,
  output logic [NFLAGS-1:0] flagMask,
  output logic [NFLAGS-1:0] flagNext,
  output logic [NFLAGS-1:0] flags
);

  aluStrobe_t        strobe;
  logic [NFLAGS-1:0] rawFlags;
  logic [NFLAGS-1:0] flagsQ;

  alu8_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  alu8_datapath #(.WIDTH(WIDTH)) u_dp (
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .zPrev    (flagsQ[FZ]),
    .result   (result),
    .rawFlags (rawFlags)
  );

  for (genvar i = 0; i < NFLAGS; i++) begin : g_merge
    assign flagNext[i] = strobe.mask[i] ? rawFlags[i] : flagsQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagsQ <= '0;
    else if (opValid) flagsQ <= flagNext;
  end

  assign flags       = flagsQ;
  assign flagMask    = strobe.mask;
  assign resultWrite = strobe.writeRes;

  p_keep_unmasked_r13: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> ((flagsQ ^ $past(flagsQ)) & ~$past(flagMask)) == '0);

  p_sign_rule_r13: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (flagMask[FN] || flagMask[FV])) |=> (flagsQ[FS] == (flagsQ[FN] ^ flagsQ[FV])));

  p_compare_nowrite_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CP || opSel == OP_CPC) |-> !resultWrite);

  p_swap_flags_r12: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_SWAP) |=> flagsQ == $past(flagsQ));

  p_logic_vclr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR || opSel == OP_COM))
      |=> !flagsQ[FV]);

  p_com_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == OP_COM) |=> flagsQ[FC]);

  p_sticky_z_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opSel == OP_SBC || opSel == OP_CPC) && !flagsQ[FZ]) |=> !flagsQ[FZ]);

endmodule

// File: tb/alu8_bench.sv
`timescale 1ns/1ps
module alu8_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] opA = '0, opB = '0;
  logic       carryIn = 1'b0;
  logic [7:0] result;
  logic       resultWrite;
  logic [5:0] flagMask, flagNext, flags;

  int checks = 0;
  int errors = 0;
  logic [5:0] expF = '0;

  always #4 clk = ~clk;

  alu8 u_alu8 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .opA(opA), .opB(opB), .carryIn(carryIn), .result(result),
    .resultWrite(resultWrite), .flagMask(flagMask), .flagNext(flagNext),
    .flags(flags)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // independent reference: flag order C0 Z1 N2 V3 S4 H5
  function automatic void model(input int op, input int a, input int b, input bit cin,
                                input logic [5:0] oldF, output logic [7:0] r,
                                output bit wr, output logic [5:0] nf);
    int t, ci, sd;
    bit c, h, v, n, z, sticky;
    logic [5:0] m;
    c = 0; h = 0; v = 0; sticky = 0; wr = 1; m = 6'b000000; r = 0; t = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(cin) : 0;
        t = a + b + ci; r = t[7:0]; c = t > 255;
        h = ((a & 15) + (b & 15) + ci) > 15;
        sd = sx(a) + sx(b) + ci; v = (sd > 127) || (sd < -128);
        m = 6'b111111;
      end
      2, 3, 4, 5: begin
        ci = (op == 3 || op == 5) ? int'(cin) : 0;
        t = a - b - ci; r = t[7:0]; c = t < 0;
        h = ((a & 15) - (b & 15) - ci) < 0;
        sd = sx(a) - sx(b) - ci; v = (sd > 127) || (sd < -128);
        sticky = (op == 3 || op == 5); wr = (op < 4); m = 6'b111111;
      end
      10: begin
        t = 0 - a; r = t[7:0]; c = a != 0; h = (a & 15) != 0; v = (a == 128);
        m = 6'b111111;
      end
      6: begin r = 8'(a & b); m = 6'b011110; end
      7: begin r = 8'(a | b); m = 6'b011110; end
      8: begin r = 8'(a ^ b); m = 6'b011110; end
      9: begin r = 8'(255 - a); c = 1; m = 6'b011111; end
      11: begin r = 8'((a + 1) & 255); v = (a == 127); m = 6'b011110; end
      12: begin r = 8'((a + 255) & 255); v = (a == 128); m = 6'b011110; end
      13: begin r = 8'((a << 1) & 255); c = a[7]; m = 6'b011111; end
      14: begin r = 8'(a >> 1); c = a[0]; m = 6'b011111; end
      15: begin r = 8'(((a << 1) | int'(cin)) & 255); c = a[7]; m = 6'b011111; end
      16: begin r = 8'((a >> 1) | (int'(cin) << 7)); c = a[0]; m = 6'b011111; end
      17: begin r = 8'((a >> 1) | (a & 128)); c = a[0]; m = 6'b011111; end
      18: begin r = 8'(((a & 15) << 4) | (a >> 4)); end
      default: wr = 0;
    endcase
    n = r[7];
    if (op >= 13 && op <= 17) v = n ^ c;
    z = (r == 0);
    if (sticky) z = z & oldF[1];
    nf = oldF;
    if (m[0]) nf[0] = c;
    if (m[1]) nf[1] = z;
    if (m[2]) nf[2] = n;
    if (m[3]) nf[3] = v;
    if (m[4]) nf[4] = n ^ v;
    if (m[5]) nf[5] = h;
  endfunction

  task automatic run(string tag, int op, int a, int b, bit cin);
    logic [7:0] r; bit wr; logic [5:0] nf;
    model(op, a, b, cin, expF, r, wr, nf);
    @(negedge clk);
    opValid = 1'b1; opSel = 5'(op); opA = 8'(a); opB = 8'(b); carryIn = cin;
    #1;
    chk(tag, "resultWrite", {7'b0, resultWrite}, {7'b0, wr});
    if (wr) chk(tag, "result", result, r);
    chk(tag, "flagNext", {2'b0, flagNext}, {2'b0, nf});
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    chk(tag, "flags", {2'b0, flags}, {2'b0, nf});
    expF = nf;
  endtask

  task automatic t_reset;
    chk("R13", "reset flags", {2'b0, flags}, 8'h00);
  endtask

  task automatic t_add;
    run("R1", 0, 8'h0F, 8'h01, 0);
    run("R1", 0, 8'h7F, 8'h01, 0);
    run("R1", 0, 8'hFF, 8'h01, 0);
    run("R1", 1, 8'h10, 8'h20, 1);
    run("R1", 1, 8'h80, 8'h80, 1);
  endtask

  task automatic t_sub;
    run("R2", 2, 8'h10, 8'h01, 0);
    run("R2", 2, 8'h80, 8'h01, 0);
    run("R2", 2, 8'h01, 8'h02, 0);
    run("R2", 3, 8'h05, 8'h05, 1);
  endtask

  task automatic t_sticky;
    run("R3", 2, 8'h33, 8'h33, 0);
    run("R3", 5, 8'h00, 8'h00, 0);
    run("R3", 5, 8'h03, 8'h01, 0);
    run("R3", 5, 8'h00, 8'h00, 0);
    run("R3", 3, 8'h07, 8'h07, 0);
  endtask

  task automatic t_compare;
    run("R4", 4, 8'h20, 8'h30, 0);
    run("R4", 4, 8'h44, 8'h44, 0);
    run("R4", 5, 8'h10, 8'h0F, 1);
  endtask

  task automatic t_logic;
    run("R5", 0, 8'h0F, 8'h01, 0);
    run("R5", 6, 8'hF0, 8'h0F, 0);
    run("R5", 7, 8'h80, 8'h01, 0);
    run("R5", 8, 8'hAA, 8'hAA, 0);
  endtask

  task automatic t_com;
    run("R6", 1, 8'h08, 8'h08, 0);
    run("R6", 9, 8'hFF, 8'h00, 0);
    run("R6", 9, 8'h12, 8'h00, 0);
  endtask

  task automatic t_neg;
    run("R7", 10, 8'h00, 8'h00, 0);
    run("R7", 10, 8'h80, 8'h00, 0);
    run("R7", 10, 8'h01, 8'h00, 0);
  endtask

  task automatic t_incdec;
    run("R8", 2, 8'h00, 8'h01, 0);
    run("R8", 11, 8'h7F, 8'h00, 0);
    run("R8", 11, 8'hFF, 8'h00, 0);
    run("R8", 12, 8'h80, 8'h00, 0);
    run("R8", 12, 8'h00, 8'h00, 0);
  endtask

  task automatic t_shift;
    run("R9", 13, 8'h81, 8'h00, 1);
    run("R9", 13, 8'h40, 8'h00, 0);
    run("R9", 14, 8'h81, 8'h00, 1);
    run("R9", 14, 8'h01, 8'h00, 0);
  endtask

  task automatic t_rotate;
    run("R10", 15, 8'h80, 8'h00, 1);
    run("R10", 15, 8'h01, 8'h00, 0);
    run("R10", 16, 8'h01, 8'h00, 1);
    run("R10", 16, 8'h02, 8'h00, 0);
  endtask

  task automatic t_asr;
    run("R11", 17, 8'h81, 8'h00, 0);
    run("R11", 17, 8'h40, 8'h00, 1);
  endtask

  task automatic t_swap;
    run("R12", 2, 8'h01, 8'h02, 0);
    run("R12", 18, 8'hA5, 8'h00, 1);
    run("R12", 18, 8'h00, 8'h00, 0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    opValid = 1'b0; opSel = 5'd0; opA = 8'h00; opB = 8'h00; carryIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R13", "flags without opValid", {2'b0, flags}, {2'b0, expF});
  endtask

  task automatic t_undef;
    run("R14", 19, 8'h00, 8'h00, 1);
    run("R14", 31, 8'hFF, 8'hFF, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R13 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_sticky();
    t_compare();
    t_logic();
    t_com();
    t_neg();
    t_incdec();
    t_shift();
    t_rotate();
    t_asr();
    t_swap();
    t_hold();
    t_undef();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule